// File: doc/BRIEF.md
# Compare-Branch Resolution with Delay-Slot Nullification

This block resolves conditional branches for a single-issue 32-bit pipeline that has one architectural delay slot. Decode hands it a branch operation together with two register operands, an encoded 5-bit immediate, a bit position, the scattered displacement fields and the PC of the branch. From these it decides whether the branch is taken, computes the byte target and decides whether the instruction in the delay slot must be squashed.

Three kinds of branch are handled: a compare of two registers, a compare of an immediate against a register, and a test of one register bit. A compare uses a 3-bit relation code and an inversion bit. Each compare opcode also comes in a "true" sense and a "false" sense. When the nullify request is set, the effect on the delay slot depends on the branch outcome and also on whether the displacement points forward or backward. All results are registered once and qualified by a valid strobe.

Top module: `cmpbr_resolve`

## Requirements
- R1: With operation 0x20 and inversion clear, relation code 1 takes the branch when A == B, 2 when A < B signed, 3 when A <= B signed, 4 when A < B unsigned and 5 when A <= B unsigned. Codes 0, 6 and 7 are never taken.
- R2: The inversion bit and operation 0x22 each complement the relation result. When both are present they cancel. For example, code 0 under exactly one of them is always taken.
- R3: Operations 0x21 (true sense) and 0x23 (false sense) compare the immediate, as the left operand, against B. In the 5-bit immediate field, bit 0 is the sign and bits 4:1 are value bits 3:0, so the value runs from -16 to 15.
- R4: Operation 0x31 tests bit A[31-p] for position p, so position 0 is the MSB. Code 2 takes the branch when that bit is 1 and code 6 when it is 0. Any other code is never taken, and the inversion bit is ignored.
- R5: The 12-bit word displacement is {sign, field[0], field[10:1]}. The target is PC + 8 + (sign-extended displacement << 2), modulo 2^32, and it is produced for every operation.
- R6: When the nullify request is clear, the slot-kill output is 0.
- R7: When the nullify request is set on a branch operation, a forward displacement (sign 0) kills the slot exactly when the branch is taken. A backward displacement (sign 1) kills it exactly when the branch is not taken.
- R8: Any operation other than 0x20, 0x21, 0x22, 0x23 and 0x31 gives taken 0 and slot-kill 0.
- R9: Results appear one clock after an input-valid cycle, with the valid output high for that single cycle. Taken, target and slot-kill hold their values while input-valid is low.
- R10: During reset and immediately after it, valid, taken, slot-kill and target are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A branch operation is presented this cycle |
| br_op | input | 6 | Major operation code |
| br_cc | input | 3 | Relation code, or bit-test polarity code |
| cc_neg | input | 1 | Inverts the compare relation |
| nul_req | input | 1 | Nullification requested for the delay slot |
| src_a | input | 32 | First register operand; the tested register for bit tests |
| src_b | input | 32 | Second register operand |
| imm_fld | input | 5 | Encoded immediate, with the sign in bit 0 |
| bit_pos | input | 5 | Bit position, where 0 is the MSB |
| disp_sign | input | 1 | Displacement sign bit |
| disp_fld | input | 11 | Scattered low displacement bits |
| pc | input | 32 | Byte address of the branch |
| out_valid | output | 1 | Registered results are valid |
| br_taken | output | 1 | Branch taken |
| br_target | output | 32 | Byte target address |
| slot_kill | output | 1 | Squash the delay-slot instruction |

## Verification
The bench builds the block with its default parameters: 32-bit data and addresses, a 5-bit immediate, an 11-bit displacement field and a slot offset of 8. At these widths, operands such as 0x80000000 against 0x7FFFFFFF make the signed and unsigned orderings disagree. The immediate extremes -16 and 15, and bit positions 0 and 31 at the two ends of the register, are also in reach. The displacement extremes of -2048 and +2047 words push the target across the address wrap. A behavioural model predicts every output on every clock. It is exercised with directed corner cases and with random operands over all relation codes, both senses, both inversion settings and both branch directions.

// File: rtl/cmpbr_pkg.sv
package cmpbr_pkg;

  localparam logic [5:0] OPC_CMP_T  = 6'h20;
  localparam logic [5:0] OPC_CMPI_T = 6'h21;
  localparam logic [5:0] OPC_CMP_F  = 6'h22;
  localparam logic [5:0] OPC_CMPI_F = 6'h23;
  localparam logic [5:0] OPC_BITTST = 6'h31;

  typedef enum logic [2:0] {
    CC_NEVER = 3'd0,
    CC_EQ    = 3'd1,
    CC_SLT   = 3'd2,
    CC_SLE   = 3'd3,
    CC_ULT   = 3'd4,
    CC_ULE   = 3'd5,
    CC_RSV6  = 3'd6,
    CC_RSV7  = 3'd7
  } cmp_cc_e;

  localparam logic [2:0] BIT_IS_ONE  = 3'd2;
  localparam logic [2:0] BIT_IS_ZERO = 3'd6;

endpackage

// File: rtl/cmpbr_cond_eval.sv
module cmpbr_cond_eval #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  input  logic [2:0]        cc,
  input  logic              invert,
  output logic              hit
);
  import cmpbr_pkg::*;

  logic eq, ult, slt, rel;

  always_comb begin
    eq  = (lhs == rhs);
    ult = (lhs < rhs);
    slt = ($signed(lhs) < $signed(rhs));
    case (cmp_cc_e'(cc))
      CC_EQ:   rel = eq;
      CC_SLT:  rel = slt;
      CC_SLE:  rel = slt | eq;
      CC_ULT:  rel = ult;
      CC_ULE:  rel = ult | eq;
      default: rel = 1'b0;
    endcase
    hit = rel ^ invert;
  end
endmodule

// File: rtl/cmpbr_bit_test.sv
module cmpbr_bit_test #(
  parameter int DATA_W = 32,
  localparam int POS_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data,
  input  logic [POS_W-1:0]  pos,
  input  logic [2:0]        cc,
  output logic              hit
);
  import cmpbr_pkg::*;

  // Reverse the bit order so that position 0 selects the MSB.
  logic [DATA_W-1:0] msb_first;
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign msb_first[i] = data[DATA_W-1-i];
  end

  logic sel;
  always_comb begin
    sel = msb_first[pos];
    if (cc == BIT_IS_ONE)       hit = sel;
    else if (cc == BIT_IS_ZERO) hit = ~sel;
    else                        hit = 1'b0;
  end
endmodule

// File: rtl/cmpbr_target.sv
module cmpbr_target #(
  parameter int ADDR_W   = 32,
  parameter int FLD_W    = 11,
  parameter int SLOT_OFS = 8,
  localparam int DISP_W  = FLD_W + 1
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic              sign,
  input  logic [FLD_W-1:0]  fld,
  output logic [ADDR_W-1:0] target,
  output logic              backward
);
  logic [DISP_W-1:0] disp_words;
  logic [ADDR_W-1:0] disp_bytes;

  always_comb begin
    // field bit 0 carries the displacement bit just under the sign
    disp_words = {sign, fld[0], fld[FLD_W-1:1]};
    disp_bytes = {{(ADDR_W-DISP_W-2){sign}}, disp_words, 2'b00};
    target     = pc + ADDR_W'(SLOT_OFS) + disp_bytes;
    backward   = sign;
  end
endmodule

// File: rtl/cmpbr_resolve.sv
module cmpbr_resolve #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 32,
  parameter int IMM_W    = 5,
  parameter int FLD_W    = 11,
  parameter int SLOT_OFS = 8,
  localparam int POS_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [5:0]        br_op,
  input  logic [2:0]        br_cc,
  input  logic              cc_neg,
  input  logic              nul_req,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm_fld,
  input  logic [POS_W-1:0]  bit_pos,
  input  logic              disp_sign,
  input  logic [FLD_W-1:0]  disp_fld,
  input  logic [ADDR_W-1:0] pc,
  output logic              out_valid,
  output logic              br_taken,
  output logic [ADDR_W-1:0] br_target,
  output logic              slot_kill
);
  import cmpbr_pkg::*;

  logic              is_reg_cmp, is_imm_cmp, is_bit, is_false, is_branch;
  logic [DATA_W-1:0] imm_ext, lhs;
  logic              cmp_hit, bit_hit, backward;
  logic [ADDR_W-1:0] target_d;
  logic              taken_d, kill_d;

  // Immediate: sign kept in bit 0, magnitude bits above it.
  assign imm_ext = {{(DATA_W-IMM_W){imm_fld[0]}}, imm_fld[0], imm_fld[IMM_W-1:1]};

  always_comb begin
    is_reg_cmp = (br_op == OPC_CMP_T)  || (br_op == OPC_CMP_F);
    is_imm_cmp = (br_op == OPC_CMPI_T) || (br_op == OPC_CMPI_F);
    is_bit     = (br_op == OPC_BITTST);
    is_false   = (br_op == OPC_CMP_F)  || (br_op == OPC_CMPI_F);
    is_branch  = is_reg_cmp | is_imm_cmp | is_bit;
    lhs        = is_imm_cmp ? imm_ext : src_a;
  end

  cmpbr_cond_eval #(.DATA_W(DATA_W)) u_cond (
    .lhs    (lhs),
    .rhs    (src_b),
    .cc     (br_cc),
    .invert (cc_neg ^ is_false),
    .hit    (cmp_hit)
  );

  cmpbr_bit_test #(.DATA_W(DATA_W)) u_bit (
    .data (src_a),
    .pos  (bit_pos),
    .cc   (br_cc),
    .hit  (bit_hit)
  );

  cmpbr_target #(.ADDR_W(ADDR_W), .FLD_W(FLD_W), .SLOT_OFS(SLOT_OFS)) u_tgt (
    .pc       (pc),
    .sign     (disp_sign),
    .fld      (disp_fld),
    .target   (target_d),
    .backward (backward)
  );

  // Next-state: outcome and delay-slot squash.
  always_comb begin
    if (is_reg_cmp || is_imm_cmp) taken_d = cmp_hit;
    else if (is_bit)              taken_d = bit_hit;
    else                          taken_d = 1'b0;
    kill_d = is_branch & nul_req & (backward ? ~taken_d : taken_d);
  end

  // Registers with explicit load enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      br_taken  <= 1'b0;
      slot_kill <= 1'b0;
      br_target <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        br_taken  <= taken_d;
        slot_kill <= kill_d;
        br_target <= target_d;
      end
    end
  end
endmodule

// File: rtl/cmpbr_resolve_chk.sv
module cmpbr_resolve_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [5:0]        br_op,
  input logic              nul_req,
  input logic              disp_sign,
  input logic [1:0]        pc_lo,
  input logic              out_valid,
  input logic              br_taken,
  input logic [ADDR_W-1:0] br_target,
  input logic              slot_kill
);
  import cmpbr_pkg::*;

  logic known_op;
  assign known_op = (br_op == OPC_CMP_T) || (br_op == OPC_CMP_F) ||
                    (br_op == OPC_CMPI_T) || (br_op == OPC_CMPI_F) ||
                    (br_op == OPC_BITTST);

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r9_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(br_taken) && $stable(slot_kill) && $stable(br_target)));
  a_r5_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (br_target[1:0] == $past(pc_lo)));
  a_r6_no_kill: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !nul_req) |=> !slot_kill);
  a_r7_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && nul_req && known_op && !disp_sign) |=> (slot_kill == br_taken));
  a_r7_backward: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && nul_req && known_op && disp_sign) |=> (slot_kill != br_taken));
  a_r8_other_op: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !known_op) |=> (!br_taken && !slot_kill));
endmodule

bind cmpbr_resolve cmpbr_resolve_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .br_op     (br_op),
  .nul_req   (nul_req),
  .disp_sign (disp_sign),
  .pc_lo     (pc[1:0]),
  .out_valid (out_valid),
  .br_taken  (br_taken),
  .br_target (br_target),
  .slot_kill (slot_kill)
);

// File: tb/cmpbr_resolve_tb_top.sv
module cmpbr_resolve_tb_top;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [5:0]  br_op;
  logic [2:0]  br_cc;
  logic        cc_neg;
  logic        nul_req;
  logic [31:0] src_a, src_b, pc;
  logic [4:0]  imm_fld, bit_pos;
  logic        disp_sign;
  logic [10:0] disp_fld;
  logic        out_valid, br_taken, slot_kill;
  logic [31:0] br_target;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 0;

  logic        e_taken = 0, e_kill = 0;
  logic [31:0] e_target = 0;

  cmpbr_resolve dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .br_op(br_op),
    .br_cc(br_cc), .cc_neg(cc_neg), .nul_req(nul_req), .src_a(src_a),
    .src_b(src_b), .imm_fld(imm_fld), .bit_pos(bit_pos),
    .disp_sign(disp_sign), .disp_fld(disp_fld), .pc(pc),
    .out_valid(out_valid), .br_taken(br_taken), .br_target(br_target),
    .slot_kill(slot_kill)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference for the branch outcome.
  function automatic bit ref_taken(input logic [5:0] op, input logic [2:0] c,
      input bit ng, input logic [31:0] a, input logic [31:0] b,
      input logic [4:0] im, input logic [4:0] ps);
    longint sa, sb;
    longint ua, ub;
    bit rel;
    int iv;
    if (op == 6'h31) begin
      if (c == 3'd2) return a[31 - ps];
      if (c == 3'd6) return !a[31 - ps];
      return 0;
    end
    if (op != 6'h20 && op != 6'h21 && op != 6'h22 && op != 6'h23) return 0;
    if (op == 6'h21 || op == 6'h23) begin
      iv = int'(im[4:1]) - (im[0] ? 16 : 0);
      a  = 32'(iv);
    end
    sa = longint'($signed(a)); sb = longint'($signed(b));
    ua = longint'({32'd0, a}); ub = longint'({32'd0, b});
    case (c)
      3'd1: rel = (ua == ub);
      3'd2: rel = (sa < sb);
      3'd3: rel = (sa <= sb);
      3'd4: rel = (ua < ub);
      3'd5: rel = (ua <= ub);
      default: rel = 0;
    endcase
    return rel ^ ng ^ (op == 6'h22 || op == 6'h23);
  endfunction

  function automatic string taken_tag(input logic [5:0] op, input bit ng);
    if (op == 6'h20 && !ng) return "R1";
    if (op == 6'h20 || op == 6'h22) return "R2";
    if (op == 6'h21 || op == 6'h23) return "R3";
    if (op == 6'h31) return "R4";
    return "R8";
  endfunction

  task automatic step(input bit v, input logic [5:0] op, input logic [2:0] c,
      input bit ng, input logic [31:0] a, input logic [31:0] b,
      input logic [4:0] im, input logic [4:0] ps, input bit sg,
      input logic [10:0] fl, input bit nb, input logic [31:0] p);
    int  dw;
    bit  tk, isbr;
    string tt;
    @(negedge clk);
    in_valid = v; br_op = op; br_cc = c; cc_neg = ng; src_a = a; src_b = b;
    imm_fld = im; bit_pos = ps; disp_sign = sg; disp_fld = fl; nul_req = nb;
    pc = p;
    tt = taken_tag(op, ng);
    if (v) begin
      tk   = ref_taken(op, c, ng, a, b, im, ps);
      isbr = (op == 6'h20 || op == 6'h21 || op == 6'h22 || op == 6'h23 || op == 6'h31);
      dw   = int'({fl[0], fl[10:1]}) - (sg ? 2048 : 0);
      e_taken  = tk;
      e_kill   = isbr && nb && (sg ? !tk : tk);
      e_target = p + 32'd8 + 32'(dw * 4);
    end
    @(posedge clk);
    #1;
    check("R9", "out_valid", {31'd0, out_valid}, {31'd0, v});
    if (v) begin
      check(tt, "taken", {31'd0, br_taken}, {31'd0, e_taken});
      check("R5", "target", br_target, e_target);
      check(nb ? "R7" : "R6", "slot_kill", {31'd0, slot_kill}, {31'd0, e_kill});
    end else begin
      check("R9", "taken held", {31'd0, br_taken}, {31'd0, e_taken});
      check("R9", "kill held", {31'd0, slot_kill}, {31'd0, e_kill});
      check("R9", "target held", br_target, e_target);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_valid = 0; br_op = 0; br_cc = 0; cc_neg = 0; nul_req = 0;
    src_a = 0; src_b = 0; imm_fld = 0; bit_pos = 0; disp_sign = 0;
    disp_fld = 0; pc = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R10", "reset valid", {31'd0, out_valid}, 32'd0);
    check("R10", "reset taken", {31'd0, br_taken}, 32'd0);
    check("R10", "reset kill", {31'd0, slot_kill}, 32'd0);
    check("R10", "reset target", br_target, 32'd0);
    @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    check("R10", "post-reset valid", {31'd0, out_valid}, 32'd0);

    // R1: each relation on signed/unsigned-disagreeing operands
    for (int c = 0; c < 8; c++) begin
      step(1, 6'h20, 3'(c), 0, 32'h8000_0000, 32'h7FFF_FFFF, 0, 0, 0, 11'd4, 0, 32'h1000);
      step(1, 6'h20, 3'(c), 0, 32'h5, 32'h5, 0, 0, 0, 11'd4, 0, 32'h1000);
    end
    // R2: inversion, false sense, both together
    for (int c = 0; c < 8; c++) begin
      step(1, 6'h20, 3'(c), 1, 32'h3, 32'h9, 0, 0, 0, 0, 0, 32'h2000);
      step(1, 6'h22, 3'(c), 0, 32'h3, 32'h9, 0, 0, 0, 0, 0, 32'h2000);
      step(1, 6'h22, 3'(c), 1, 32'h3, 32'h9, 0, 0, 0, 0, 0, 32'h2000);
    end
    // R3: immediate extremes -16 (5'b00001) and 15 (5'b11110)
    step(1, 6'h21, 3'd1, 0, 0, 32'hFFFF_FFF0, 5'b00001, 0, 0, 0, 0, 32'h40);
    step(1, 6'h21, 3'd1, 0, 0, 32'd15, 5'b11110, 0, 0, 0, 0, 32'h40);
    step(1, 6'h21, 3'd4, 0, 0, 32'd1, 5'b00001, 0, 0, 0, 0, 32'h40);
    step(1, 6'h23, 3'd2, 0, 0, 32'd0, 5'b00011, 0, 0, 0, 0, 32'h40);
    // R4: MSB at position 0, LSB at 31, both polarities, other code
    step(1, 6'h31, 3'd2, 0, 32'h8000_0000, 0, 0, 5'd0, 0, 0, 0, 32'h80);
    step(1, 6'h31, 3'd6, 1, 32'h8000_0000, 0, 0, 5'd0, 0, 0, 0, 32'h80);
    step(1, 6'h31, 3'd2, 0, 32'h0000_0001, 0, 0, 5'd31, 0, 0, 0, 32'h80);
    step(1, 6'h31, 3'd6, 0, 32'h0000_0001, 0, 0, 5'd30, 0, 0, 0, 32'h80);
    step(1, 6'h31, 3'd1, 0, 32'hFFFF_FFFF, 0, 0, 5'd4, 0, 0, 0, 32'h80);
    // R5: displacement extremes and wrap
    step(1, 6'h20, 3'd1, 0, 1, 1, 0, 0, 1, 11'd0, 0, 32'h0000_0100);
    step(1, 6'h20, 3'd1, 0, 1, 1, 0, 0, 0, 11'h7FF, 0, 32'hFFFF_FFF0);
    step(1, 6'h20, 3'd1, 0, 1, 1, 0, 0, 0, 11'h001, 0, 32'h0000_0000);
    // R7: forward/backward with taken/not taken
    step(1, 6'h20, 3'd1, 0, 7, 7, 0, 0, 0, 11'd8, 1, 32'h300);
    step(1, 6'h20, 3'd1, 0, 7, 8, 0, 0, 0, 11'd8, 1, 32'h300);
    step(1, 6'h20, 3'd1, 0, 7, 7, 0, 0, 1, 11'd8, 1, 32'h300);
    step(1, 6'h20, 3'd1, 0, 7, 8, 0, 0, 1, 11'd8, 1, 32'h300);
    // R8: unrelated operations with nullify requested
    step(1, 6'h02, 3'd1, 0, 7, 7, 0, 0, 0, 11'd8, 1, 32'h300);
    step(1, 6'h30, 3'd2, 0, 32'hFFFF_FFFF, 0, 0, 0, 1, 0, 1, 32'h300);
    // R9: idle cycles hold results
    step(0, 6'h20, 3'd1, 0, 1, 1, 0, 0, 1, 11'h555, 1, 32'h9999);
    step(0, 6'h31, 3'd2, 0, 0, 0, 0, 0, 0, 0, 0, 32'h0);

    // Random sweep
    for (int k = 0; k < 4000; k++) begin
      logic [5:0]  op;
      logic [31:0] a, b;
      int sel;
      sel = $urandom_range(0, 5);
      case (sel)
        0: op = 6'h20; 1: op = 6'h21; 2: op = 6'h22;
        3: op = 6'h23; 4: op = 6'h31; default: op = 6'($urandom);
      endcase
      a = $urandom;
      b = ($urandom_range(0, 3) == 0) ? a : 32'($urandom);
      if ($urandom_range(0, 3) == 0) b = {a[31], 31'($urandom_range(0, 3))};
      step($urandom_range(0, 4) != 0, op, 3'($urandom), 1'($urandom), a, b,
           5'($urandom), 5'($urandom), 1'($urandom), 11'($urandom),
           1'($urandom), $urandom);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule